// File: doc/BRIEF.md
# Prescaled Timer / Event Counter

This block is a 16-bit up-counter made of a low byte and a high byte. It counts one of two sources. The first is an internal timebase that ticks once every `DIV` clock cycles, with `DIV` = 12 by default. The second is the falling edge of an asynchronous event pin. The pin passes through a synchronizer. An edge that is detected is held as pending and is counted on the next timebase tick, so at most one event is counted per timebase period.

The two bytes either cascade into one 16-bit counter or run split as two 8-bit counters. In split mode the low byte counts the selected source, and the high byte always counts the internal timebase. A full-scale rollover sets a sticky flag, and each flag drives its own interrupt-request output.

Software uses a small register port to load the counts, read them back, and set or clear the control and flag bits. A separate acknowledge input clears each flag.

Top module: `evtcnt_top`

## Requirements
- R1: With source select 0, run 1 and cascade mode, the count rises by exactly one on each internal tick. A tick occurs once every `DIV` (12) clocks. The prescaler phase runs freely from reset.
- R2: With source select 1, a 1-to-0 transition on `ext_evt` is synchronized through two flops. It is then counted on the next internal tick. Several transitions inside one tick period count as one.
- R3: In cascade mode (split bit 0), the high byte increments in the same cycle that the low byte rolls from 0xFF to 0x00.
- R4: In split mode (split bit 1), the low byte counts the selected source. The high byte counts internal ticks on its own, with no carry from the low byte.
- R5: While the run bit is 0, neither byte changes except by a register write.
- R6: A rollover of the whole counter (0xFFFF to 0x0000 in cascade mode, or the low byte 0xFF to 0x00 in split mode) sets flag `ovf`. A rollover of the high byte in split mode sets flag `ovf_hi`. `irq` and `irq_hi` equal these flags.
- R7: Each flag is sticky. A control write with the flag's bit at 0 clears it. A one-cycle pulse on its acknowledge input also clears it. A rollover in the same cycle as an acknowledge leaves the flag set.
- R8: A write to a byte takes priority over an increment of that byte in the same cycle. A control write sets the flags to the written bits, whatever else happens in that cycle.
- R9: Reset clears both bytes, all control bits, both flags and the prescaler phase.
- R10: Register map at `wr_addr`/`rd_addr`:
  - Address 0 is the low byte.
  - Address 1 is the high byte.
  - Address 2 is the control register: bit0 run, bit1 source select (1 = pin), bit2 split, bit3 `ovf`, bit4 `ovf_hi`. Its upper bits read 0.
  - Address 3 reads 0.

  `rd_data` is combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_evt | input | 1 | Asynchronous event pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data of the addressed register |
| irq_ack | input | 1 | Clears `ovf` |
| irq_ack_hi | input | 1 | Clears `ovf_hi` |
| irq | output | 1 | Interrupt request, equals `ovf` |
| irq_hi | output | 1 | Interrupt request, equals `ovf_hi` |

## Verification
The bench builds the block with its defaults: `DIV` = 12 and two synchronizer stages. A wrap of the 16-bit count can then be reached within a few hundred cycles, because the bytes are loaded just below full scale. The short divider lets pin bursts faster than one per tick be placed in the same period as a single edge, which exercises the collapse of several edges into one count. It also lets byte writes land on tick cycles, and acknowledge pulses land on rollover cycles.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  // control register bit positions (software-visible)
  localparam int CB_RUN   = 0;
  localparam int CB_SRC   = 1;
  localparam int CB_SPLIT = 2;
  localparam int CB_OVF   = 3;
  localparam int CB_OVFH  = 4;

  localparam logic [ADDR_W-1:0] A_LO  = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd2;

  typedef struct packed {
    logic split;
    logic src_ext;
    logic run;
  } ctl_t;

  // increment one byte, carry in the top bit
  function automatic logic [BYTE_W:0] bump_byte(input logic [BYTE_W-1:0] v);
    return {1'b0, v} + {{BYTE_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic byte_full(input logic [BYTE_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/evtcnt_prescale.sv
module evtcnt_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/evtcnt_edge.sv
module evtcnt_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic base_tick,
  output logic ext_tick
);
  logic [SYNC-1:0] chain;
  logic            prev;
  logic            synced;
  logic            fall;
  logic            pending;

  genvar g;
  generate
    for (g = 0; g < SYNC; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign synced   = chain[SYNC-1];
  assign fall     = prev & ~synced;
  assign ext_tick = base_tick & (pending | fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev    <= synced;
      pending <= base_tick ? 1'b0 : (pending | fall);
    end
  end

  AST_EXT_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |-> base_tick); // R2
  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !base_tick) |=> pending); // R2
endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core
  import evtcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ack_lo,
  input  logic              ack_hi,
  input  logic              base_tick,
  input  logic              ext_tick,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output ctl_t              ctl,
  output logic              ovf,
  output logic              ovf_hi
);
  logic              src_tick;
  logic              inc_lo, inc_hi_split, lo_carry, hi_carry_casc;
  logic              ovf_evt, ovfh_evt;
  logic              wr_lo, wr_hi, wr_ctl;
  logic [BYTE_W:0]   lo_sum, hi_sum;
  logic [BYTE_W-1:0] lo_n, hi_n;

  assign wr_lo  = wr_en && (wr_addr == A_LO);
  assign wr_hi  = wr_en && (wr_addr == A_HI);
  assign wr_ctl = wr_en && (wr_addr == A_CTL);

  assign src_tick      = ctl.src_ext ? ext_tick : base_tick;
  assign inc_lo        = ctl.run & src_tick;
  assign inc_hi_split  = ctl.run & base_tick & ctl.split;
  assign lo_sum        = bump_byte(cnt_lo);
  assign hi_sum        = bump_byte(cnt_hi);
  assign lo_carry      = inc_lo & lo_sum[BYTE_W];
  assign hi_carry_casc = lo_carry & ~ctl.split;

  // rollover events brought out for assertions
  assign ovf_evt  = lo_carry & (ctl.split | byte_full(cnt_hi));
  assign ovfh_evt = inc_hi_split & byte_full(cnt_hi);

  always_comb begin
    lo_n = inc_lo ? lo_sum[BYTE_W-1:0] : cnt_lo;
    if (wr_lo) lo_n = wr_data;
    hi_n = (hi_carry_casc | inc_hi_split) ? hi_sum[BYTE_W-1:0] : cnt_hi;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      ctl    <= '0;
      ovf    <= 1'b0;
      ovf_hi <= 1'b0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
      if (wr_ctl) begin
        ctl.run     <= wr_data[CB_RUN];
        ctl.src_ext <= wr_data[CB_SRC];
        ctl.split   <= wr_data[CB_SPLIT];
        ovf         <= wr_data[CB_OVF];
        ovf_hi      <= wr_data[CB_OVFH];
      end else begin
        if (ovf_evt) ovf <= 1'b1;
        else if (ack_lo) ovf <= 1'b0;
        if (ovfh_evt) ovf_hi <= 1'b1;
        else if (ack_hi) ovf_hi <= 1'b0;
      end
    end
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo})); // R5
  AST_CASCADE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.split && inc_lo && byte_full(cnt_lo) && !wr_en)
      |=> (cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + 1'b1)); // R3
  AST_ROLL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !wr_ctl) |=> ovf); // R6
  AST_ROLL_SETS_FLAG_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfh_evt && !wr_ctl) |=> ovf_hi); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ack_lo && !wr_ctl) |=> ovf); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data))); // R8
  AST_SPLIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.split && !base_tick && !wr_hi) |=> $stable(cnt_hi)); // R4
endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
  import evtcnt_pkg::*;
#(
  parameter int DIV  = 12,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              irq_ack,
  input  logic              irq_ack_hi,
  output logic              irq,
  output logic              irq_hi
);
  logic              base_tick, ext_tick;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;
  ctl_t              ctl;
  logic              ovf, ovf_hi;

  evtcnt_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(base_tick)
  );

  evtcnt_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_evt),
    .base_tick(base_tick), .ext_tick(ext_tick)
  );

  evtcnt_core u_core (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_lo(irq_ack), .ack_hi(irq_ack_hi),
    .base_tick(base_tick), .ext_tick(ext_tick),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ctl(ctl),
    .ovf(ovf), .ovf_hi(ovf_hi)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_LO:  rd_data = cnt_lo;
      A_HI:  rd_data = cnt_hi;
      A_CTL: begin
        rd_data[CB_RUN]   = ctl.run;
        rd_data[CB_SRC]   = ctl.src_ext;
        rd_data[CB_SPLIT] = ctl.split;
        rd_data[CB_OVF]   = ovf;
        rd_data[CB_OVFH]  = ovf_hi;
      end
      default: rd_data = '0;
    endcase
  end

  assign irq    = ovf;
  assign irq_hi = ovf_hi;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !ovf_evt_q() && !(wr_en && wr_addr == A_CTL)) |=> !irq); // R7

  function automatic logic ovf_evt_q();
    return u_core.ovf_evt;
  endfunction
endmodule

// File: tb/test_evtcnt_top.sv
module test_evtcnt_top;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_evt = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_ack = 1'b0, irq_ack_hi = 1'b0;
  logic       irq, irq_hi;

  always #5 clk = ~clk;

  evtcnt_top i_evtcnt_top (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_ack(irq_ack), .irq_ack_hi(irq_ack_hi),
    .irq(irq), .irq_hi(irq_hi)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R9";
  bit    auto_rd = 1'b0;
  bit    live = 1'b0;

  // behavioural reference state
  int m_lo, m_hi, m_ph;
  bit m_run, m_src, m_split, m_f, m_fh, m_pend;
  int pinq[$];

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_read(int a);
    case (a)
      0: return m_lo;
      1: return m_hi;
      2: return m_run + 2*m_src + 4*m_split + 8*m_f + 16*m_fh;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_ph = 0; m_run = 0; m_src = 0; m_split = 0;
      m_f = 0; m_fh = 0; m_pend = 0;
      pinq = '{0, 0, 0};
    end else begin
      bit tk, fall, ext, st, ev, evh;
      int total, nlo, nhi;
      tk   = (m_ph == DIV - 1);
      fall = (pinq[2] == 1) && (pinq[1] == 0);
      ext  = tk && (m_pend || fall);
      st   = m_src ? ext : tk;
      nlo = m_lo; nhi = m_hi; ev = 0; evh = 0;
      if (m_run && st) begin
        if (!m_split) begin
          total = m_hi * 256 + m_lo;
          ev = (total == 65535);
          total = (total + 1) % 65536;
          nlo = total % 256; nhi = total / 256;
        end else begin
          ev = (m_lo == 255);
          nlo = (m_lo + 1) % 256;
        end
      end
      if (m_split && m_run && tk) begin
        evh = (m_hi == 255);
        nhi = (m_hi + 1) % 256;
      end
      if (wr_en && wr_addr == 0) nlo = wr_data;
      if (wr_en && wr_addr == 1) nhi = wr_data;
      if (wr_en && wr_addr == 2) begin
        m_run = wr_data[0]; m_src = wr_data[1]; m_split = wr_data[2];
        m_f = wr_data[3]; m_fh = wr_data[4];
      end else begin
        if (ev) m_f = 1; else if (irq_ack) m_f = 0;
        if (evh) m_fh = 1; else if (irq_ack_hi) m_fh = 0;
      end
      m_lo = nlo; m_hi = nhi;
      m_pend = tk ? 0 : (m_pend || fall);
      m_ph = (m_ph + 1) % DIV;
      pinq.push_front(int'(ext_evt));
      void'(pinq.pop_back());
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (live) begin
      chk(cur_req, "rd_data", int'(rd_data), m_read(int'(rd_addr)));
      chk(cur_req, "irq", int'(irq), int'(m_f));
      chk(cur_req, "irq_hi", int'(irq_hi), int'(m_fh));
    end
  end

  always @(negedge clk) if (auto_rd) rd_addr <= rd_addr + 2'd1;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    auto_rd = 1'b0;
    @(negedge clk); rd_addr = a; #1;
    chk(req, "directed read", int'(rd_data), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    // R9: reset state, R10 map
    cur_req = "R9";
    rd_chk(2'd0, 0, "R9"); rd_chk(2'd1, 0, "R9"); rd_chk(2'd2, 0, "R9");
    rd_chk(2'd3, 0, "R10");
    chk("R9", "irq", int'(irq), 0);

    // R1: cascade timer counting
    cur_req = "R1"; auto_rd = 1'b1;
    wr(2'd2, 8'h01);
    idle(300);

    // R3/R6: cascade wrap of the full count
    cur_req = "R3";
    wr(2'd2, 8'h00); wr(2'd0, 8'hF0); wr(2'd1, 8'hFF); wr(2'd2, 8'h01);
    idle(230);
    cur_req = "R6";
    rd_chk(2'd2, 8'h09, "R6");
    chk("R6", "irq", int'(irq), 1);

    // R7: sticky flag, acknowledge clears
    cur_req = "R7"; auto_rd = 1'b1;
    wr(2'd2, 8'h08);
    idle(30);
    chk("R7", "irq sticky", int'(irq), 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    #1 chk("R7", "irq after ack", int'(irq), 0);
    wr(2'd2, 8'h08); wr(2'd2, 8'h00);
    #1 chk("R7", "irq after ctl clear", int'(irq), 0);

    // R5: held while stopped
    cur_req = "R5";
    wr(2'd0, 8'h37);
    idle(100);
    rd_chk(2'd0, 8'h37, "R5");

    // R8: byte writes every cycle while running
    cur_req = "R8"; auto_rd = 1'b1;
    wr(2'd2, 8'h01);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 2'(i % 2); wr_data = 8'(8'hF8 + i);
    end
    @(negedge clk); wr_en = 1'b0;
    idle(40);

    // R7: acks around rollovers (set wins over ack)
    cur_req = "R7";
    wr(2'd2, 8'h05); wr(2'd0, 8'hFC);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); irq_ack = (i % 5 == 0);
    end
    @(negedge clk); irq_ack = 1'b0;

    // R2: external events, slow edges
    cur_req = "R2";
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h03);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_evt = 1'b1; idle(20);
      @(negedge clk); ext_evt = 1'b0; idle(20);
    end
    idle(30);
    rd_chk(2'd0, 5, "R2");
    auto_rd = 1'b1;
    // fast bursts collapse into one count per tick
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ext_evt = ~ext_evt;
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ext_evt = (i % 7 < 3);
    end
    ext_evt = 1'b0;
    idle(30);

    // R4: split mode with internal and external low-byte sources
    cur_req = "R4";
    wr(2'd2, 8'h00); wr(2'd0, 8'hFE); wr(2'd1, 8'hFE); wr(2'd2, 8'h05);
    idle(40);
    chk("R4", "irq", int'(irq), 1);
    chk("R4", "irq_hi", int'(irq_hi), 1);
    @(negedge clk); irq_ack_hi = 1'b1; @(negedge clk); irq_ack_hi = 1'b0;
    #1 chk("R7", "irq_hi after ack", int'(irq_hi), 0);
    wr(2'd2, 8'h07); wr(2'd1, 8'hFD);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); ext_evt = (i % 9 < 4);
    end
    idle(40);

    live = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule